// File: doc/BRIEF.md
# Hot Loop Profiler

This block watches the retired-instruction stream of a processor and finds the loops where execution time goes. A loop is recognised only when a retired branch is taken with a negative displacement. Such a backward branch closes one pass of a loop. A small fully associative table keeps one row per loop, or per nesting level of nested loops. Each row is keyed by the address of the closing branch and holds four values: the loop's first address, its closing address, the instructions counted against it, and how many passes it has made.

A free-running instruction counter advances on every retired instruction. When a backward branch retires, the counter's value, including the branch itself, is credited to that loop's row, and the counter starts again from zero. Instructions executed between two backward branches are therefore charged to whichever loop closes next. When a row's total first rises above a threshold that can be changed at run time, the block presents that row as a candidate for acceleration with a one-cycle valid pulse. A synchronous clear empties the table between profiling runs.

Top module: `loop_heat_profiler`

## Requirements
- R1: After reset the table is empty, the instruction counter is zero and `cand_valid_o` is low.
- R2: A loop event happens only in a cycle where `retire_i`, `br_taken_i` and the sign bit of `br_off_i` (two's complement, MSB set means negative) are all high. Not-taken branches, taken branches with zero or positive displacement, and branch inputs without `retire_i` leave the table untouched and are counted only if retired.
- R3: The counter increments once per retired instruction. A loop event credits the count including the branch itself, then the counter returns to zero.
- R4: A loop event whose `pc_i` equals the closing address of a valid row adds the credited count to that row's total and increments its pass count.
- R5: A loop event that matches no row fills the lowest-numbered empty row. The new row gets first address `pc_i + br_off_i` (sign-extended), closing address `pc_i`, total equal to the credited count, and pass count 1.
- R6: When the table is full, a missing loop replaces the row with the smallest total, taking the lowest index among equal totals.
- R7: If a row's total after an update is strictly greater than `thresh_i`, `cand_valid_o` is high for exactly the next cycle. In that cycle the report lines carry the row index, first and closing addresses, the updated total and the pass count.
- R8: A row is reported at most once between its allocation and its replacement or clearing.
- R9: Row totals, pass counts and the instruction counter stop at their all-ones value instead of wrapping.
- R10: `tbl_clear_i` empties every row, zeroes the counter and suppresses any report from a loop event in the same cycle.
- R11: Nested loops occupy separate rows. Instructions of an outer loop that precede an inner loop's first backward branch are charged to the inner loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| tbl_clear_i | input | 1 | Synchronous clear of table and counter |
| retire_i | input | 1 | One instruction retires this cycle |
| pc_i | input | ADDR_W | Address of the retiring instruction |
| br_taken_i | input | 1 | Retiring instruction is a taken branch |
| br_off_i | input | OFF_W | Signed branch displacement |
| thresh_i | input | CNT_W | Candidate threshold |
| cand_valid_o | output | 1 | One-cycle candidate report strobe |
| cand_idx_o | output | IDX_W | Table row of the candidate |
| cand_start_o | output | ADDR_W | First address of the loop |
| cand_end_o | output | ADDR_W | Closing branch address |
| cand_total_o | output | CNT_W | Instruction total at report time |
| cand_iters_o | output | ITER_W | Pass count at report time |

## Verification
A single loop run against a fixed threshold shows that each pass is credited with its full length. It also shows that the report comes on the first pass to exceed the threshold and never again. A mix of forward, not-taken and unretired branches separates real loop events from branches that must only be counted. Two nested loops show how the count is split between nesting levels. Filling all eight rows with distinct totals shows that the smallest total is evicted and that a later hit still finds its own row. A long loop driven to the ceiling of a narrow counter checks saturation and the strict comparison. A clear issued in the same cycle as a backward branch shows that the clear wins and that the counter is reset with it.

// File: rtl/lprof_pkg.sv
// Shared declarations of the hot loop profiler.
// Assumes nothing beyond the 1800-2017 language.
package lprof_pkg;

    // How a loop event finds its table row.
    typedef enum logic [1:0] {
        ALLOC_HIT   = 2'd0,
        ALLOC_FREE  = 2'd1,
        ALLOC_EVICT = 2'd2
    } alloc_kind_e;

endpackage

// File: rtl/lprof_icount.sv
// Instruction counter between backward branches.
// Counts retired instructions and saturates at all ones.
// add_o is the value to credit if the instruction retiring now closes a
// loop: it includes that instruction. Assumes event_i implies retire_i.
module lprof_icount #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             retire_i,
    input  logic             event_i,
    output logic [CNT_W-1:0] add_o
);

    logic [CNT_W-1:0] cnt_q;

    // Saturating successor of the running count.
    always_comb begin
        add_o = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
    end

    // Count retired instructions; restart after a loop event or clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i || event_i) begin
            cnt_q <= '0;
        end else if (retire_i) begin
            cnt_q <= add_o;
        end
    end

endmodule

// File: rtl/lprof_victim.sv
// Row selection for a missing loop.
// Finds the lowest empty row, and the row with the smallest total (lowest
// index among equals) for use when no row is empty. Purely combinational.
module lprof_victim #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 32,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] valid_i,
    input  logic [CNT_W-1:0] totals_i [DEPTH],
    output logic             free_found_o,
    output logic [IDX_W-1:0] free_idx_o,
    output logic [IDX_W-1:0] min_idx_o
);

    logic [CNT_W-1:0] min_val;

    // Lowest-index empty row: scan downwards so the lowest wins.
    always_comb begin
        free_found_o = 1'b0;
        free_idx_o   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_found_o = 1'b1;
                free_idx_o   = IDX_W'(i);
            end
        end
    end

    // Smallest total; strict compare keeps the lower index on ties.
    always_comb begin
        min_idx_o = '0;
        min_val   = totals_i[0];
        for (int i = 1; i < DEPTH; i++) begin
            if (totals_i[i] < min_val) begin
                min_val   = totals_i[i];
                min_idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lprof_entry.sv
// One row of the associative loop table.
// Holds first and closing address, instruction total, pass count and a
// reported flag. Matches on the closing address. Totals and pass counts
// saturate. Assumes wr_hit_i and wr_new_i are never high together.
module lprof_entry #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 32,
    parameter int ITER_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              wr_hit_i,
    input  logic              wr_new_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [CNT_W-1:0]  add_i,
    input  logic              set_rep_i,
    output logic              valid_o,
    output logic              match_o,
    output logic              rep_o,
    output logic [ADDR_W-1:0] start_o,
    output logic [CNT_W-1:0]  total_o,
    output logic [CNT_W-1:0]  total_upd_o,
    output logic [ITER_W-1:0] iters_upd_o
);

    logic              valid_q;
    logic              rep_q;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;
    logic [CNT_W-1:0]  total_q;
    logic [ITER_W-1:0] iters_q;
    logic [CNT_W:0]    sum;

    // Match and saturating update values.
    always_comb begin
        match_o     = valid_q && (end_q == pc_i);
        sum         = {1'b0, total_q} + {1'b0, add_i};
        total_upd_o = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        iters_upd_o = (&iters_q) ? iters_q : iters_q + ITER_W'(1);
    end

    assign valid_o = valid_q;
    assign rep_o   = rep_q;
    assign start_o = start_q;
    assign total_o = total_q;

    // Row state: clear, fresh allocation, or accumulation on a hit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_q <= 1'b0;
            rep_q   <= 1'b0;
            start_q <= '0;
            end_q   <= '0;
            total_q <= '0;
            iters_q <= '0;
        end else if (clear_i) begin
            valid_q <= 1'b0;
            rep_q   <= 1'b0;
            total_q <= '0;
            iters_q <= '0;
        end else if (wr_new_i) begin
            valid_q <= 1'b1;
            rep_q   <= set_rep_i;
            start_q <= start_i;
            end_q   <= pc_i;
            total_q <= add_i;
            iters_q <= ITER_W'(1);
        end else if (wr_hit_i) begin
            rep_q   <= rep_q | set_rep_i;
            total_q <= total_upd_o;
            iters_q <= iters_upd_o;
        end
    end

endmodule

// File: rtl/loop_heat_profiler.sv
// Hot loop profiler top.
// Detects retired taken backward branches and credits the running
// instruction count to a fully associative row keyed by the branch address.
// It allocates or evicts rows on a miss and reports each row once, when
// its total first exceeds thresh_i. Assumes at most one instruction retires
// per cycle and that ADDR_W >= OFF_W.
module loop_heat_profiler
    import lprof_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12,
    parameter int CNT_W  = 32,
    parameter int ITER_W = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tbl_clear_i,
    input  logic              retire_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              br_taken_i,
    input  logic [OFF_W-1:0]  br_off_i,
    input  logic [CNT_W-1:0]  thresh_i,
    output logic              cand_valid_o,
    output logic [IDX_W-1:0]  cand_idx_o,
    output logic [ADDR_W-1:0] cand_start_o,
    output logic [ADDR_W-1:0] cand_end_o,
    output logic [CNT_W-1:0]  cand_total_o,
    output logic [ITER_W-1:0] cand_iters_o
);

    logic              loop_ev;
    logic [CNT_W-1:0]  add_val;
    logic [ADDR_W-1:0] start_new;

    logic [DEPTH-1:0]  e_valid;
    logic [DEPTH-1:0]  e_match;
    logic [DEPTH-1:0]  e_rep;
    logic [DEPTH-1:0]  wr_hit;
    logic [DEPTH-1:0]  wr_new;
    logic [ADDR_W-1:0] e_start     [DEPTH];
    logic [CNT_W-1:0]  e_total     [DEPTH];
    logic [CNT_W-1:0]  e_total_upd [DEPTH];
    logic [ITER_W-1:0] e_iters_upd [DEPTH];

    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx;
    logic              free_found;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  min_idx;
    alloc_kind_e       kind;
    logic [IDX_W-1:0]  tgt_idx;
    logic [CNT_W-1:0]  new_total;
    logic [ITER_W-1:0] new_iters;
    logic [ADDR_W-1:0] rep_start;
    logic              fire;

    // Loop event: retired, taken, negative displacement, not cleared.
    always_comb begin
        loop_ev   = retire_i && br_taken_i && br_off_i[OFF_W-1] && !tbl_clear_i;
        start_new = pc_i + ADDR_W'($signed(br_off_i));
    end

    lprof_icount #(
        .CNT_W (CNT_W)
    ) u_icount (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (tbl_clear_i),
        .retire_i (retire_i),
        .event_i  (loop_ev),
        .add_o    (add_val)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        lprof_entry #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .ITER_W (ITER_W)
        ) u_entry (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .clear_i     (tbl_clear_i),
            .pc_i        (pc_i),
            .wr_hit_i    (wr_hit[g]),
            .wr_new_i    (wr_new[g]),
            .start_i     (start_new),
            .add_i       (add_val),
            .set_rep_i   (fire),
            .valid_o     (e_valid[g]),
            .match_o     (e_match[g]),
            .rep_o       (e_rep[g]),
            .start_o     (e_start[g]),
            .total_o     (e_total[g]),
            .total_upd_o (e_total_upd[g]),
            .iters_upd_o (e_iters_upd[g])
        );
    end

    lprof_victim #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_victim (
        .valid_i      (e_valid),
        .totals_i     (e_total),
        .free_found_o (free_found),
        .free_idx_o   (free_idx),
        .min_idx_o    (min_idx)
    );

    // Encode the matching row; closing addresses are unique in the table.
    always_comb begin
        hit_any = |e_match;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (e_match[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    // Choose the target row and the values it will hold after the event.
    always_comb begin
        if (hit_any) begin
            kind      = ALLOC_HIT;
            tgt_idx   = hit_idx;
            new_total = e_total_upd[hit_idx];
            new_iters = e_iters_upd[hit_idx];
            rep_start = e_start[hit_idx];
        end else begin
            kind      = free_found ? ALLOC_FREE : ALLOC_EVICT;
            tgt_idx   = free_found ? free_idx : min_idx;
            new_total = add_val;
            new_iters = ITER_W'(1);
            rep_start = start_new;
        end
        fire = loop_ev && (new_total > thresh_i) && !(hit_any && e_rep[hit_idx]);
    end

    // Per-row write strobes.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            wr_hit[i] = loop_ev && (kind == ALLOC_HIT) && (tgt_idx == IDX_W'(i));
            wr_new[i] = loop_ev && (kind != ALLOC_HIT) && (tgt_idx == IDX_W'(i));
        end
    end

    // Candidate report register: one-cycle pulse with the row's contents.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cand_valid_o <= 1'b0;
            cand_idx_o   <= '0;
            cand_start_o <= '0;
            cand_end_o   <= '0;
            cand_total_o <= '0;
            cand_iters_o <= '0;
        end else begin
            cand_valid_o <= fire;
            if (fire) begin
                cand_idx_o   <= tgt_idx;
                cand_start_o <= rep_start;
                cand_end_o   <= pc_i;
                cand_total_o <= new_total;
                cand_iters_o <= new_iters;
            end
        end
    end

endmodule

// File: rtl/lprof_checker.sv
// Property checker for the hot loop profiler, bound to the top module.
// Relates the report port to the inputs of the previous cycle.
module lprof_checker #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12,
    parameter int CNT_W  = 32,
    parameter int ITER_W = 16,
    parameter int IDX_W  = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tbl_clear_i,
    input logic              retire_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              br_taken_i,
    input logic [OFF_W-1:0]  br_off_i,
    input logic [CNT_W-1:0]  thresh_i,
    input logic              cand_valid_o,
    input logic [IDX_W-1:0]  cand_idx_o,
    input logic [ADDR_W-1:0] cand_end_o,
    input logic [CNT_W-1:0]  cand_total_o,
    input logic [ITER_W-1:0] cand_iters_o
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rst_ni) |-> !cand_valid_o); // R1

    AST_REPORT_NEEDS_BACK_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_valid_o |-> $past(retire_i && br_taken_i && br_off_i[OFF_W-1])); // R2

    AST_REPORT_ABOVE_THRESH: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_valid_o |-> (cand_total_o > $past(thresh_i))); // R7

    AST_REPORT_END_IS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_valid_o |-> (cand_end_o == $past(pc_i))); // R4

    AST_REPORT_HAS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_valid_o |-> (cand_iters_o != '0)); // R5

    AST_CLEAR_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni) tbl_clear_i |=> !cand_valid_o); // R10

    AST_IDX_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_valid_o |-> !$isunknown(cand_idx_o)); // R7

endmodule

bind loop_heat_profiler lprof_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W),
    .ITER_W (ITER_W),
    .IDX_W  (IDX_W)
) i_lprof_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tbl_clear_i  (tbl_clear_i),
    .retire_i     (retire_i),
    .pc_i         (pc_i),
    .br_taken_i   (br_taken_i),
    .br_off_i     (br_off_i),
    .thresh_i     (thresh_i),
    .cand_valid_o (cand_valid_o),
    .cand_idx_o   (cand_idx_o),
    .cand_end_o   (cand_end_o),
    .cand_total_o (cand_total_o),
    .cand_iters_o (cand_iters_o)
);

// File: tb/test_loop_heat_profiler.sv
// Directed bench for the hot loop profiler: one task per scenario.
module test_loop_heat_profiler;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 12;
    localparam int CNT_W  = 8;
    localparam int ITER_W = 8;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              retire = 1'b0;
    logic [ADDR_W-1:0] pc = '0;
    logic              taken = 1'b0;
    logic [OFF_W-1:0]  off = '0;
    logic [CNT_W-1:0]  thresh = '1;
    logic              cv;
    logic [IDX_W-1:0]  cidx;
    logic [ADDR_W-1:0] cstart;
    logic [ADDR_W-1:0] cend;
    logic [CNT_W-1:0]  ctotal;
    logic [ITER_W-1:0] citers;

    int  n_chk = 0;
    int  n_err = 0;
    int  n_rep = 0;
    bit  done = 1'b0;
    logic              s_v;
    logic [IDX_W-1:0]  s_idx;
    logic [ADDR_W-1:0] s_start;
    logic [ADDR_W-1:0] s_end;
    logic [CNT_W-1:0]  s_total;
    logic [ITER_W-1:0] s_iters;

    always #(CLK_PERIOD / 2) clk = ~clk;

    loop_heat_profiler #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .CNT_W  (CNT_W),
        .ITER_W (ITER_W),
        .DEPTH  (DEPTH)
    ) i_loop_heat_profiler (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tbl_clear_i  (clr),
        .retire_i     (retire),
        .pc_i         (pc),
        .br_taken_i   (taken),
        .br_off_i     (off),
        .thresh_i     (thresh),
        .cand_valid_o (cv),
        .cand_idx_o   (cidx),
        .cand_start_o (cstart),
        .cand_end_o   (cend),
        .cand_total_o (ctotal),
        .cand_iters_o (citers)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present one cycle of inputs, then sample the report one edge later.
    task automatic step(input int a, input bit tk, input int d, input bit ret, input bit c);
        retire = ret;
        pc     = ADDR_W'(a);
        taken  = tk;
        off    = OFF_W'(d);
        clr    = c;
        @(negedge clk);
        s_v     = cv;
        s_idx   = cidx;
        s_start = cstart;
        s_end   = cend;
        s_total = ctotal;
        s_iters = citers;
        if (cv === 1'b1) n_rep++;
        retire = 1'b0;
        taken  = 1'b0;
        clr    = 1'b0;
    endtask

    task automatic plain(input int a);
        step(a, 1'b0, 0, 1'b1, 1'b0);
    endtask

    task automatic back(input int a, input int d);
        step(a, 1'b1, d, 1'b1, 1'b0);
    endtask

    task automatic do_clear();
        step(0, 1'b0, 0, 1'b0, 1'b1);
    endtask

    task automatic expect_none(input string req);
        chk(req, "no report", longint'(s_v), 0);
    endtask

    task automatic expect_rep(input string req, input int idx, input int st, input int en,
                              input int tot, input int it);
        chk(req, "report valid", longint'(s_v), 1);
        chk(req, "report index", longint'(s_idx), idx);
        chk(req, "report start", longint'(s_start), st);
        chk(req, "report end", longint'(s_end), en);
        chk(req, "report total", longint'(s_total), tot);
        chk(req, "report passes", longint'(s_iters), it);
    endtask

    // R1: quiet after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", longint'(cv), 0);
    endtask

    // R3 R4 R5 R7 R8: one four-instruction loop, threshold 10.
    task automatic t_single();
        thresh = 8'd10;
        for (int k = 1; k <= 4; k++) begin
            plain(16'h10);
            plain(16'h11);
            plain(16'h12);
            back(16'h13, -3);
            if (k == 3) expect_rep("R7", 0, 16'h10, 16'h13, 12, 3);
            else        expect_none(k == 4 ? "R8" : "R3");
        end
    endtask

    // R2: only retired taken negative branches close a loop.
    task automatic t_ignored();
        do_clear();
        thresh = 8'd0;
        step(16'h30, 1'b1, -5, 1'b0, 1'b0);
        expect_none("R2");
        step(16'h31, 1'b1, 4, 1'b1, 1'b0);
        expect_none("R2");
        step(16'h32, 1'b0, -2, 1'b1, 1'b0);
        expect_none("R2");
        back(16'h33, -3);
        expect_rep("R2", 0, 16'h30, 16'h33, 3, 1);
    endtask

    task automatic outer_pass();
        plain(16'h40);
        plain(16'h41);
        for (int p = 0; p < 3; p++) begin
            plain(16'h42);
            plain(16'h43);
            step(16'h44, p < 2, -2, 1'b1, 1'b0);
        end
        plain(16'h45);
        back(16'h46, -6);
    endtask

    // R11: nested loops keep separate rows.
    task automatic t_nested();
        int base;
        do_clear();
        thresh = 8'd12;
        base = n_rep;
        outer_pass();
        chk("R11", "reports after pass 1", n_rep - base, 0);
        plain(16'h40);
        plain(16'h41);
        plain(16'h42);
        plain(16'h43);
        back(16'h44, -2);
        expect_rep("R11", 0, 16'h42, 16'h44, 13, 3);
        plain(16'h42);
        plain(16'h43);
        back(16'h44, -2);
        expect_none("R8");
        plain(16'h42);
        plain(16'h43);
        step(16'h44, 1'b0, -2, 1'b1, 1'b0);
        plain(16'h45);
        back(16'h46, -6);
        expect_none("R11");
        thresh = 8'd9;
        outer_pass();
        expect_rep("R11", 1, 16'h40, 16'h46, 15, 3);
    endtask

    // R6 R4: fill the table and force an eviction.
    task automatic t_replace();
        int base;
        int n_plain[8] = '{2, 3, 4, 0, 5, 6, 7, 8};
        do_clear();
        thresh = '1;
        base = n_rep;
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < n_plain[k]; j++) plain(16'h100);
            back(16'h200 + 16 * k, -4);
        end
        chk("R5", "reports while filling", n_rep - base, 0);
        thresh = 8'd5;
        for (int j = 0; j < 6; j++) plain(16'h100);
        back(16'h300, -8);
        expect_rep("R6", 3, 16'h2F8, 16'h300, 7, 1);
        for (int j = 0; j < 4; j++) plain(16'h100);
        back(16'h200, -4);
        expect_rep("R4", 0, 16'h1FC, 16'h200, 8, 2);
    endtask

    // R9 R7: saturation at 255 and strict comparison at 250.
    task automatic t_saturate();
        do_clear();
        thresh = 8'd250;
        for (int k = 1; k <= 27; k++) begin
            for (int j = 0; j < 9; j++) plain(16'h77 + j);
            back(16'h80, -9);
            if (k == 25) expect_none("R7");
            if (k == 26) expect_rep("R9", 0, 16'h77, 16'h80, 255, 26);
            if (k == 27) expect_none("R8");
        end
    endtask

    // R10: clear wins over a same-cycle event and resets the counter.
    task automatic t_clear();
        do_clear();
        thresh = 8'd100;
        back(16'h500, -1);
        back(16'h500, -1);
        plain(16'h501);
        plain(16'h502);
        plain(16'h503);
        thresh = 8'd0;
        step(16'h500, 1'b1, -1, 1'b1, 1'b1);
        expect_none("R10");
        back(16'h600, -2);
        expect_rep("R10", 0, 16'h5FE, 16'h600, 1, 1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_ignored();
        t_nested();
        t_replace();
        t_saturate();
        t_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule